// File: doc/BRIEF.md
# Status Byte and Service Request Unit

This block assembles an eight-bit instrument status byte from six summary lines that other status logic drives. It keeps an eight-bit enable mask for service requests and drives a service-request line. The summary bits follow their inputs directly and are never latched. One bit position is not stored at all. It is computed from the masked summary bits, and what it reports depends on which read path asks for it.

There are two ways to read the status byte. A command-style read returns the live master summary in the computed bit. A serial-poll read returns a request flag in that bit. The flag sets when the master summary rises and clears once a poll has reported it. The service-request line follows that flag. The enable mask can be written and read back through a small register port. Every read answers one cycle after its strobe, with a single-cycle valid pulse.

Top module: `svc_status_core`

## Requirements
- R1: The status byte places the summary lines as follows: bit 0 measurement, bit 2 error-available, bit 3 questionable, bit 4 message-available, bit 5 event, bit 7 operation. Bit 1 reads 0. A read reports the lines as sampled in the strobe cycle.
- R2: Summary bits are not latched. A line that drops to 0 reads as 0 on the next status or poll read.
- R3: The master summary is the OR over bits 0, 2, 3, 4, 5 and 7 of (status byte AND enable mask). A command-style status read returns it in bit 6.
- R4: The request flag sets on the clock edge after a cycle in which the master summary is 1 and was 0 in the previous cycle. Just after reset, the previous value counts as 0.
- R5: `srq` is 1 exactly while the request flag is set.
- R6: A serial-poll read returns the status byte with bit 6 equal to the request flag in the strobe cycle. The poll clears the flag on the following edge. If the master summary rises in that same strobe cycle, the flag stays set. While the master summary stays at 1, the flag does not set again.
- R7: An enable write stores the written byte with bits 6 and 1 forced to 0. An enable read returns the stored mask. A read in the same cycle as a write returns the old mask.
- R8: `rd_data` and `rd_valid` are registered and appear in the cycle after a strobe. With no strobe, `rd_valid` is 0 and `rd_data` is 0. When several strobes arrive together, poll wins over status, and status wins over enable read.
- R9: Synchronous reset clears the mask, the request flag, `rd_data`, `rd_valid` and `srq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sum_meas | input | 1 | Measurement summary line (bit 0) |
| sum_err | input | 1 | Error-available summary line (bit 2) |
| sum_ques | input | 1 | Questionable summary line (bit 3) |
| sum_msg | input | 1 | Message-available summary line (bit 4) |
| sum_evt | input | 1 | Event summary line (bit 5) |
| sum_oper | input | 1 | Operation summary line (bit 7) |
| en_we | input | 1 | Enable-mask write strobe |
| en_wdata | input | 8 | Enable-mask write value |
| en_rd | input | 1 | Enable-mask read strobe |
| stat_rd | input | 1 | Command-style status read strobe |
| poll_rd | input | 1 | Serial-poll read strobe |
| rd_data | output | 8 | Read result, one cycle after the strobe |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| srq | output | 1 | Service-request line |

## Verification
The bench builds the unit with its default parameters: an eight-bit byte, the computed bit at position 6, the unused bit at position 1, and the variant in which a rise wins over a poll that lands in the same cycle. With these values the bench can drive the same-cycle rise-and-poll case, which shows the set-wins choice at the ports. It can also drive the same-cycle write-and-read case and combinations of strobes that test the priority order. Long random stretches toggle the mask and the summary lines together, so the master summary rises, holds and falls while polls arrive in many different phases.

// File: rtl/svc_status_pkg.sv
package svc_status_pkg;

   localparam int SB_W     = 8;
   localparam int POS_SVC  = 6;
   localparam int POS_RSVD = 1;

   typedef enum logic [1:0] {
      RK_NONE = 2'd0,
      RK_MASK = 2'd1,
      RK_STAT = 2'd2,
      RK_POLL = 2'd3
   } rd_kind_t;

endpackage

// File: rtl/svc_enable_reg.sv
module svc_enable_reg #(
   parameter int W        = 8,
   parameter int MSS_POS  = 6,
   parameter int RSVD_POS = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask
);

   function automatic logic [W-1:0] keep_bits();
      logic [W-1:0] k;
      for (int i = 0; i < W; i++) begin
         k[i] = (i != MSS_POS) && (i != RSVD_POS);
      end
      return k;
   endfunction

   localparam logic [W-1:0] KEEP = keep_bits();

   if (MSS_POS < 0 || MSS_POS >= W || RSVD_POS < 0 || RSVD_POS >= W
       || MSS_POS == RSVD_POS) begin : g_bad_pos
      $error("svc_enable_reg: bad reserved bit positions");
   end

   logic [W-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (rst)     mask_q <= '0;
      else if (we) mask_q <= wdata & KEEP;
   end

   assign mask = mask_q;

   // R7: without a write the mask does not move
   p_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(mask));

endmodule

// File: rtl/svc_summary.sv
module svc_summary #(
   parameter int W        = 8,
   parameter int MSS_POS  = 6,
   parameter int RSVD_POS = 1,
   localparam int NS      = W - 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [NS-1:0] sum_in,
   input  logic [W-1:0]  mask,
   output logic [W-1:0]  stat_bits,
   output logic          mss
);

   logic [W-1:0] hit;

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (b == MSS_POS || b == RSVD_POS) begin : g_gap
         assign stat_bits[b] = 1'b0;
      end else begin : g_line
         localparam int IDX = b - ((b > RSVD_POS) ? 1 : 0) - ((b > MSS_POS) ? 1 : 0);
         assign stat_bits[b] = sum_in[IDX];
      end
      assign hit[b] = stat_bits[b] & mask[b] & (b != MSS_POS);
   end

   assign mss = |hit;

   // R3: an all-zero mask can never raise the master summary
   p_mss_masked_r3: assert property (@(posedge clk) disable iff (rst)
      (mask == '0) |-> !mss);

   // R1: the unused bit stays clear whatever the lines do
   p_gap_clear_r1: assert property (@(posedge clk) disable iff (rst)
      !stat_bits[RSVD_POS] && !stat_bits[MSS_POS]);

endmodule

// File: rtl/svc_request_flag.sv
module svc_request_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic mss,
   input  logic clr,
   output logic flag
);

   logic mss_q;
   logic flag_q;
   logic flag_d;
   logic rise;

   assign rise = mss & ~mss_q;

   if (SET_WINS) begin : g_set_wins
      assign flag_d = rise | (flag_q & ~clr);
   end else begin : g_clr_wins
      assign flag_d = (rise | flag_q) & ~clr;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mss_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         mss_q  <= mss;
         flag_q <= flag_d;
      end
   end

   assign flag = flag_q;

   // R6: only a poll can take the flag down
   p_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (flag && !clr) |=> flag);

   // R4: a summary rise always leaves the flag set in the set-wins variant
   if (SET_WINS) begin : g_rise_chk
      p_rise_sets_r4: assert property (@(posedge clk) disable iff (rst)
         (mss && !mss_q) |=> flag);
   end

endmodule

// File: rtl/svc_read_port.sv
module svc_read_port
   import svc_status_pkg::*;
#(
   parameter int W       = 8,
   parameter int MSS_POS = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         rd_mask,
   input  logic         rd_stat,
   input  logic         rd_poll,
   input  logic [W-1:0] mask,
   input  logic [W-1:0] stat_bits,
   input  logic         mss,
   input  logic         flag,
   output logic [W-1:0] rd_data,
   output logic         rd_valid
);

   rd_kind_t     kind;
   logic [W-1:0] data_d;
   logic [W-1:0] data_q;
   logic         vld_q;

   always_comb begin
      if (rd_poll)      kind = RK_POLL;
      else if (rd_stat) kind = RK_STAT;
      else if (rd_mask) kind = RK_MASK;
      else              kind = RK_NONE;
   end

   always_comb begin
      data_d = '0;
      case (kind)
         RK_POLL: begin
            data_d          = stat_bits;
            data_d[MSS_POS] = flag;
         end
         RK_STAT: begin
            data_d          = stat_bits;
            data_d[MSS_POS] = mss;
         end
         RK_MASK: data_d = mask;
         default: data_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         data_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         data_q <= data_d;
         vld_q  <= (kind != RK_NONE);
      end
   end

   assign rd_data  = data_q;
   assign rd_valid = vld_q;

   // R8: every strobe produces a valid pulse one cycle later
   p_valid_after_strobe_r8: assert property (@(posedge clk) disable iff (rst)
      (rd_mask || rd_stat || rd_poll) |=> rd_valid);

   // R8: idle cycles give an empty, invalid read bus
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      !(rd_mask || rd_stat || rd_poll) |=> (!rd_valid && rd_data == '0));

endmodule

// File: rtl/svc_status_core.sv
module svc_status_core #(
   parameter int DATA_W        = svc_status_pkg::SB_W,
   parameter int MSS_POS       = svc_status_pkg::POS_SVC,
   parameter int RSVD_POS      = svc_status_pkg::POS_RSVD,
   parameter bit POLL_SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sum_meas,
   input  logic              sum_err,
   input  logic              sum_ques,
   input  logic              sum_msg,
   input  logic              sum_evt,
   input  logic              sum_oper,
   input  logic              en_we,
   input  logic [DATA_W-1:0] en_wdata,
   input  logic              en_rd,
   input  logic              stat_rd,
   input  logic              poll_rd,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              srq
);

   localparam int NS = DATA_W - 2;

   if (NS != 6) begin : g_bad_width
      $error("svc_status_core: six summary lines need an eight-bit byte");
   end

   logic [NS-1:0]     sum_vec;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] stat_bits;
   logic              mss;
   logic              flag;

   assign sum_vec = {sum_oper, sum_evt, sum_msg, sum_ques, sum_err, sum_meas};

   svc_enable_reg #(.W(DATA_W), .MSS_POS(MSS_POS), .RSVD_POS(RSVD_POS)) u_mask (
      .clk(clk), .rst(rst), .we(en_we), .wdata(en_wdata), .mask(mask));

   svc_summary #(.W(DATA_W), .MSS_POS(MSS_POS), .RSVD_POS(RSVD_POS)) u_sum (
      .clk(clk), .rst(rst), .sum_in(sum_vec), .mask(mask),
      .stat_bits(stat_bits), .mss(mss));

   svc_request_flag #(.SET_WINS(POLL_SET_WINS)) u_flag (
      .clk(clk), .rst(rst), .mss(mss), .clr(poll_rd), .flag(flag));

   svc_read_port #(.W(DATA_W), .MSS_POS(MSS_POS)) u_rd (
      .clk(clk), .rst(rst), .rd_mask(en_rd), .rd_stat(stat_rd), .rd_poll(poll_rd),
      .mask(mask), .stat_bits(stat_bits), .mss(mss), .flag(flag),
      .rd_data(rd_data), .rd_valid(rd_valid));

   assign srq = flag;

   // R5: the request line can only rise after a cycle with the summary high
   p_srq_cause_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(srq) |-> $past(mss));

endmodule

// File: tb/sim_svc_status_core.sv
module sim_svc_status_core;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] s   = '0;
   logic       en_we = 1'b0, en_rd = 1'b0, stat_rd = 1'b0, poll_rd = 1'b0;
   logic [7:0] en_wdata = '0;
   logic [7:0] rd_data;
   logic       rd_valid, srq;

   always #(CLK_PERIOD/2) clk = ~clk;

   svc_status_core u0 (
      .clk(clk), .rst(rst),
      .sum_meas(s[0]), .sum_err(s[1]), .sum_ques(s[2]),
      .sum_msg(s[3]), .sum_evt(s[4]), .sum_oper(s[5]),
      .en_we(en_we), .en_wdata(en_wdata), .en_rd(en_rd),
      .stat_rd(stat_rd), .poll_rd(poll_rd),
      .rd_data(rd_data), .rd_valid(rd_valid), .srq(srq));

   int n_tests = 0;
   int n_fail  = 0;

   // reference state
   logic [7:0] m_mask = '0;
   logic       m_flag = 1'b0, m_prev = 1'b0, m_vld = 1'b0;
   logic [7:0] m_data = '0;
   string      m_tag  = "R8";

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] build_byte(input logic [5:0] v);
      logic [7:0] b;
      b    = '0;
      b[0] = v[0]; b[2] = v[1]; b[3] = v[2];
      b[4] = v[3]; b[5] = v[4]; b[7] = v[5];
      return b;
   endfunction

   function automatic void model_reset();
      m_mask = '0; m_flag = 1'b0; m_prev = 1'b0;
      m_vld = 1'b0; m_data = '0; m_tag = "R8 R9";
   endfunction

   // one cycle: compare at negedge, then drive inputs for the next edge
   task automatic cyc(input logic [5:0] sv, input logic we, input logic [7:0] wd,
                      input logic rm, input logic rs, input logic rp);
      logic [7:0] sb, nd;
      logic       mss, rise, nv;
      string      nt;
      @(negedge clk);
      check(m_tag, rd_data, m_data);
      check("R8 valid", {7'd0, rd_valid}, {7'd0, m_vld});
      check("R5 R4 srq", {7'd0, srq}, {7'd0, m_flag});
      s = sv; en_we = we; en_wdata = wd; en_rd = rm; stat_rd = rs; poll_rd = rp;
      sb   = build_byte(sv);
      mss  = |(sb & m_mask);
      rise = mss && !m_prev;
      nv   = rm || rs || rp;
      if (rp) begin
         nd = sb; nd[6] = m_flag; nt = "R6 R2 poll";
      end else if (rs) begin
         nd = sb; nd[6] = mss; nt = "R1 R2 R3 status";
      end else if (rm) begin
         nd = m_mask; nt = "R7 mask";
      end else begin
         nd = '0; nt = "R8 idle";
      end
      m_flag = rise || (m_flag && !rp);
      m_prev = mss;
      if (we) m_mask = wd & 8'hBD;
      m_data = nd; m_vld = nv; m_tag = nt;
   endtask

   task automatic idle(input logic [5:0] sv);
      cyc(sv, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; s = '0; en_we = 0; en_rd = 0; stat_rd = 0; poll_rd = 0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      model_reset();
      check("R9 data", rd_data, 8'h00);
      check("R9 valid", {7'd0, rd_valid}, 8'h00);
      check("R9 srq", {7'd0, srq}, 8'h00);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : stim
      do_reset();
      cyc('0, 1, 8'h00, 1, 0, 0);                 // R9 mask reads 0 after reset
      // R7: reserved bits forced low; same-cycle read returns old value
      cyc('0, 1, 8'hFF, 1, 0, 0);
      cyc('0, 0, 8'h00, 1, 0, 0);
      cyc('0, 1, 8'h00, 0, 0, 0);
      // R1: each line alone, then all lines, mask clear
      for (int i = 0; i < 6; i++) cyc(6'(1 << i), 0, 8'h00, 0, 1, 0);
      cyc(6'h3F, 0, 8'h00, 0, 1, 0);
      // R2: lines drop, next read shows zero
      cyc(6'h00, 0, 8'h00, 0, 1, 0);
      cyc(6'h00, 0, 8'h00, 0, 0, 1);
      // R3 R4 R5: measurement enabled, rise sets flag
      cyc(6'h00, 1, 8'h01, 0, 0, 0);
      cyc(6'h01, 0, 8'h00, 0, 1, 0);
      idle(6'h01);
      cyc(6'h01, 0, 8'h00, 0, 1, 0);
      // R6: poll returns flag and clears it; no re-set while held high
      cyc(6'h01, 0, 8'h00, 0, 0, 1);
      cyc(6'h01, 0, 8'h00, 0, 0, 1);
      idle(6'h01);
      idle(6'h00);
      idle(6'h01);                                // R4 fresh rise
      idle(6'h01);
      cyc(6'h00, 0, 8'h00, 0, 0, 1);
      // R6: rise in the same cycle as a poll keeps the flag
      cyc(6'h01, 0, 8'h00, 0, 0, 1);
      idle(6'h01);
      cyc(6'h01, 0, 8'h00, 0, 0, 1);
      // R8: strobe priority
      cyc(6'h21, 0, 8'h00, 1, 1, 1);
      cyc(6'h21, 0, 8'h00, 1, 1, 0);
      cyc(6'h21, 0, 8'h00, 1, 0, 0);
      // R3: bit 6 of mask cannot enable anything; mask via operation line
      cyc(6'h00, 1, 8'h40, 0, 0, 0);
      cyc(6'h3F, 0, 8'h00, 0, 1, 0);
      cyc(6'h20, 1, 8'h80, 0, 1, 0);
      cyc(6'h20, 0, 8'h00, 0, 1, 0);
      idle(6'h20);
      // R9: reset mid-run with flag and mask set
      do_reset();
      cyc('0, 0, 8'h00, 1, 0, 0);
      idle('0);
      // random mix
      for (int k = 0; k < 3000; k++) begin
         cyc(6'($urandom), ($urandom % 8) == 0, 8'($urandom),
             ($urandom % 5) == 0, ($urandom % 4) == 0, ($urandom % 6) == 0);
      end
      idle('0);
      idle('0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule